// File: doc/BRIEF.md
# Asynchronous Serial Port with Queued Receiver

This block is a full-duplex asynchronous serial port for a byte-wide register bus. Software loads bytes to send into a one-byte transmit holding register. It takes received bytes from the head of a small receive queue through a read-data port, and pops the queue with a read strobe. A single control/status byte carries the receive enable, the software extra bit, the received extra bit, the transmit-done and receive-done flags, and the overrun and parity-error flags. This byte is readable at all times and is written through its own strobe.

Framing is one start bit, eight data bits sent least significant bit first, an optional ninth bit, and one stop bit. Every bit lasts a parameterised number of baud-tick pulses, 16 by default. The ninth bit holds either a value set by software or a parity bit, even or odd. Baud-rate generation lies outside the block: a one-cycle tick input arrives at the oversampling rate. The transmit-done and receive-done flags are also brought out as interrupt request outputs.

Top module: `uart_fifo_port`

## Requirements
- R1: After reset, the control/status byte reads 0x20, the transmit line is high, and both interrupt outputs are low.
- R2: A frame sent on the transmit line is a low start bit, then the eight data bits least significant first, then a ninth bit when extra-bit mode or parity is on, then a high stop bit. Each bit is held for OVERSAMPLE ticks. The ninth bit is the software extra bit (status bit 3) when parity is off. With even parity it is the XOR of the data bits; with odd parity it is the inverse of that XOR.
- R3: Status bit 5 (read-only) is 1 exactly when the transmit holding register is empty. A data write while it is occupied is dropped.
- R4: The transmit-done flag (status bit 1) sets on the clock edge where the line enters the stop bit. It stays set until software writes 0 to it, and a set in the same cycle wins over the clear.
- R5: The receive line passes through two flip-flops. A start bit that is no longer low at its midpoint is rejected. Each bit is sampled at mid-bit. A completed character enters a FIFO_DEPTH-entry queue whose oldest byte shows on rd_data; a read strobe pops that byte.
- R6: While the receive enable (status bit 4) is 0, no new character is accepted, and queued bytes can still be read.
- R7: A character that completes while the queue is full is discarded, and the sticky overrun flag (status bit 7) is set.
- R8: With parity on, the sticky parity-error flag (status bit 6) is set while the oldest queued byte carries a mismatched ninth bit. A clear is overridden for as long as that byte is at the head.
- R9: While the queue holds data, status bit 2 (read-only) shows the ninth bit of the oldest byte. With the ninth bit absent, it shows the level sampled for the first stop bit. When the queue is empty, it holds its last value.
- R10: The receive-done flag (status bit 0) sets when a character completes. Writing 0 to it clears it only when the queue is empty.
- R11: On a status write, each flag in bits 7, 6, 1 and 0 is cleared by a 0 and left unchanged by a 1. Bits 4 and 3 take the written value. Bits 5 and 2 ignore writes.
- R12: tx_irq follows the transmit-done flag, and rx_irq follows the receive-done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| cfg_ninth_en | input | 1 | Extra-bit mode: frames carry a ninth bit |
| cfg_parity_en | input | 1 | Ninth bit carries parity and is present |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| wr_data_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_data_en | input | 1 | Pops the oldest received byte |
| rd_data | output | 8 | Oldest received byte (0 when the queue is empty) |
| ctl_wr_en | input | 1 | Write strobe for the control/status byte |
| ctl_wdata | input | 8 | Value written to the control/status byte |
| ctl_rdata | output | 8 | Control/status byte |
| rx_line | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit-done request |
| rx_irq | output | 1 | Receive-done request |

## Verification
On every cycle, the assertions check the following: the sticky flags stay set until a 0 is written, a write of 1 cannot raise overrun while the queue has room, and the receive-done flag stays high whenever the queue holds data. They also check that the holding-empty flag drops after an accepted write, that a frame opens with a low start bit, and that the queue count stays in range. Behaviours that depend on serial timing can only be shown by the bench's scenarios. These are the exact transmit waveform and the cycle on which the transmit-done flag sets (compared each clock against a model), and the choice of the ninth bit. The same holds for the rejection of a short glitch, the discard on overrun, the parity flag following the head byte, and the refused receive-done clear while bytes are queued.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    // control/status bit positions
    localparam int SB_OVR  = 7;
    localparam int SB_PERR = 6;
    localparam int SB_THRE = 5;
    localparam int SB_REN  = 4;
    localparam int SB_TXX  = 3;
    localparam int SB_RXX  = 2;
    localparam int SB_TI   = 1;
    localparam int SB_RI   = 0;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              perr;
    } rx_entry_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_t;

    function automatic logic parity_bit(input logic [DATA_W-1:0] d, input logic odd);
        return odd ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_fifo_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              ninth_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              soft_ninth,
    output logic              tx,
    output logic              thr_empty,
    output logic              busy,
    output logic              stop_start
);
    localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

    logic [DATA_W-1:0]  thr_q;
    logic               thr_full_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [IDX_W-1:0]   bidx_q;
    logic [IDX_W-1:0]   nbits_q;
    logic [TW-1:0]      tcnt_q;
    logic               busy_q;
    logic               has9;
    logic               ninth_val;
    logic               bit_end;
    logic [IDX_W-1:0]   bidx_nx;

    assign has9      = ninth_en | par_en;
    assign ninth_val = par_en ? parity_bit(thr_q, par_odd) : soft_ninth;
    assign bit_end   = busy_q && tick && (tcnt_q == TW'(OVERSAMPLE - 1));
    assign bidx_nx   = bidx_q + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q      <= '0;
            thr_full_q <= 1'b0;
            shreg_q    <= '1;
            bidx_q     <= '0;
            nbits_q    <= '0;
            tcnt_q     <= '0;
            busy_q     <= 1'b0;
        end else begin
            if (wr_en && !thr_full_q) begin
                thr_q      <= wr_byte;
                thr_full_q <= 1'b1;
            end
            if (!busy_q && thr_full_q) begin
                busy_q     <= 1'b1;
                thr_full_q <= 1'b0;
                tcnt_q     <= '0;
                bidx_q     <= '0;
                if (has9) begin
                    shreg_q <= {1'b1, ninth_val, thr_q, 1'b0};
                    nbits_q <= IDX_W'(FRAME_W);
                end else begin
                    shreg_q <= {2'b11, thr_q, 1'b0};
                    nbits_q <= IDX_W'(FRAME_W - 1);
                end
            end else if (busy_q && tick) begin
                if (bit_end) begin
                    tcnt_q  <= '0;
                    shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                    bidx_q  <= bidx_nx;
                    if (bidx_nx == nbits_q) begin
                        busy_q <= 1'b0;
                    end
                end else begin
                    tcnt_q <= tcnt_q + TW'(1);
                end
            end
        end
    end

    assign stop_start = bit_end && (bidx_nx == (nbits_q - IDX_W'(1)));
    assign tx         = busy_q ? shreg_q[0] : 1'b1;
    assign thr_empty  = !thr_full_q;
    assign busy       = busy_q;

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import uart_fifo_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx_pin,
    input  logic      rx_en,
    input  logic      ninth_en,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_entry_t entry
);
    localparam int TW   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int HALF = OVERSAMPLE / 2;

    logic [1:0]        sync_q;
    rx_state_t         state_q;
    logic [TW-1:0]     tcnt_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              ninth_q;
    logic              done_q;
    rx_entry_t         entry_q;
    logic              line;
    logic              has9;
    logic              sample;

    assign line   = sync_q[1];
    assign has9   = ninth_en | par_en;
    assign sample = (state_q == RX_BUSY) && tick && (tcnt_q == TW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rx_pin};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            ninth_q <= 1'b0;
            done_q  <= 1'b0;
            entry_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == RX_IDLE) begin
                if (tick && rx_en && !line) begin
                    state_q <= RX_BUSY;
                    tcnt_q  <= '0;
                    bidx_q  <= '0;
                end
            end else begin
                if (tick) begin
                    tcnt_q <= (tcnt_q == TW'(OVERSAMPLE - 1)) ? '0 : tcnt_q + TW'(1);
                end
                if (sample) begin
                    if (bidx_q == '0) begin
                        if (line) begin
                            state_q <= RX_IDLE;
                        end else begin
                            bidx_q <= IDX_W'(1);
                        end
                    end else if (bidx_q <= IDX_W'(DATA_W)) begin
                        shreg_q <= {line, shreg_q[DATA_W-1:1]};
                        bidx_q  <= bidx_q + IDX_W'(1);
                    end else if (has9 && (bidx_q == IDX_W'(DATA_W + 1))) begin
                        ninth_q <= line;
                        bidx_q  <= bidx_q + IDX_W'(1);
                    end else begin
                        done_q        <= 1'b1;
                        entry_q.data  <= shreg_q;
                        entry_q.ninth <= has9 ? ninth_q : line;
                        entry_q.perr  <= par_en && (ninth_q != parity_bit(shreg_q, par_odd));
                        state_q       <= RX_IDLE;
                    end
                end
            end
        end
    end

    assign done  = done_q;
    assign entry = entry_q;

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t        mem_q [DEPTH];
    logic [PW-1:0]    wptr_q;
    logic [PW-1:0]    rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem_q[wptr_q] <= push_entry;
                wptr_q        <= ptr_next(wptr_q);
            end
            if (do_pop) begin
                rptr_q <= ptr_next(rptr_q);
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem_q[rptr_q];
    assign count = cnt_q;

endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
    import uart_fifo_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              cfg_ninth_en,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_data_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ctl_wr_en,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              rx_line,
    output logic              tx_line,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic             ovr_q, perr_q, ren_q, txx_q, rxx_q, ti_q, ri_q;
    logic             thr_empty;
    logic             tx_busy;
    logic             stop_start;
    logic             rx_done;
    rx_entry_t        rx_entry;
    rx_entry_t        head;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_full;
    logic             fifo_empty;
    logic             pop;

    uart_tx_path #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .wr_en      (wr_data_en),
        .wr_byte    (wr_data),
        .ninth_en   (cfg_ninth_en),
        .par_en     (cfg_parity_en),
        .par_odd    (cfg_parity_odd),
        .soft_ninth (txx_q),
        .tx         (tx_line),
        .thr_empty  (thr_empty),
        .busy       (tx_busy),
        .stop_start (stop_start)
    );

    uart_rx_path #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .rx_pin   (rx_line),
        .rx_en    (ren_q),
        .ninth_en (cfg_ninth_en),
        .par_en   (cfg_parity_en),
        .par_odd  (cfg_parity_odd),
        .done     (rx_done),
        .entry    (rx_entry)
    );

    assign pop = rd_data_en && !fifo_empty;

    uart_rx_queue #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (rx_done),
        .push_entry (rx_entry),
        .pop        (pop),
        .head       (head),
        .count      (fifo_count),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    // flag clear requests: a written 0 clears, a written 1 keeps
    logic clr_ovr, clr_perr, clr_ti, clr_ri;
    assign clr_ovr  = ctl_wr_en && !ctl_wdata[SB_OVR];
    assign clr_perr = ctl_wr_en && !ctl_wdata[SB_PERR];
    assign clr_ti   = ctl_wr_en && !ctl_wdata[SB_TI];
    assign clr_ri   = ctl_wr_en && !ctl_wdata[SB_RI];

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q  <= 1'b0;
            perr_q <= 1'b0;
            ren_q  <= 1'b0;
            txx_q  <= 1'b0;
            rxx_q  <= 1'b0;
            ti_q   <= 1'b0;
            ri_q   <= 1'b0;
        end else begin
            if (rx_done && fifo_full) begin
                ovr_q <= 1'b1;
            end else if (clr_ovr) begin
                ovr_q <= 1'b0;
            end

            if (!fifo_empty && cfg_parity_en && head.perr) begin
                perr_q <= 1'b1;
            end else if (clr_perr) begin
                perr_q <= 1'b0;
            end

            if (stop_start) begin
                ti_q <= 1'b1;
            end else if (clr_ti) begin
                ti_q <= 1'b0;
            end

            if (rx_done) begin
                ri_q <= 1'b1;
            end else if (clr_ri && fifo_empty) begin
                ri_q <= 1'b0;
            end

            if (!fifo_empty) begin
                rxx_q <= head.ninth;
            end

            if (ctl_wr_en) begin
                ren_q <= ctl_wdata[SB_REN];
                txx_q <= ctl_wdata[SB_TXX];
            end
        end
    end

    always_comb begin
        ctl_rdata          = '0;
        ctl_rdata[SB_OVR]  = ovr_q;
        ctl_rdata[SB_PERR] = perr_q;
        ctl_rdata[SB_THRE] = thr_empty;
        ctl_rdata[SB_REN]  = ren_q;
        ctl_rdata[SB_TXX]  = txx_q;
        ctl_rdata[SB_RXX]  = rxx_q;
        ctl_rdata[SB_TI]   = ti_q;
        ctl_rdata[SB_RI]   = ri_q;
    end

    assign rd_data = fifo_empty ? '0 : head.data;
    assign tx_irq  = ti_q;
    assign rx_irq  = ri_q;

endmodule

// File: rtl/uart_fifo_port_chk.sv
module uart_fifo_port_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ovr,
    input logic             perr,
    input logic             thre,
    input logic             ti,
    input logic             ri,
    input logic             ctl_wr_en,
    input logic             wd_ovr,
    input logic             wd_perr,
    input logic             wd_ti,
    input logic             wr_data_en,
    input logic             tx_line,
    input logic             tx_busy,
    input logic [CNT_W-1:0] fifo_count
);

    a_r2_start_bit_low: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !tx_line);

    a_r3_thre_drops_on_write: assert property (@(posedge clk) disable iff (rst)
        (thre && wr_data_en) |=> !thre);

    a_r4_ti_sticky: assert property (@(posedge clk) disable iff (rst)
        (ti && !(ctl_wr_en && !wd_ti)) |=> ti);

    a_r5_queue_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(FIFO_DEPTH));

    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(ctl_wr_en && !wd_ovr)) |=> ovr);

    a_r8_perr_sticky: assert property (@(posedge clk) disable iff (rst)
        (perr && !(ctl_wr_en && !wd_perr)) |=> perr);

    a_r10_ri_while_queued: assert property (@(posedge clk) disable iff (rst)
        (fifo_count != '0) |-> ri);

    a_r11_ovr_write_one_no_set: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_en && wd_ovr && !ovr && fifo_count != CNT_W'(FIFO_DEPTH)) |=> !ovr);

endmodule

bind uart_fifo_port uart_fifo_port_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovr        (ovr_q),
    .perr       (perr_q),
    .thre       (thr_empty),
    .ti         (ti_q),
    .ri         (ri_q),
    .ctl_wr_en  (ctl_wr_en),
    .wd_ovr     (ctl_wdata[7]),
    .wd_perr    (ctl_wdata[6]),
    .wd_ti      (ctl_wdata[1]),
    .wr_data_en (wr_data_en),
    .tx_line    (tx_line),
    .tx_busy    (tx_busy),
    .fifo_count (fifo_count)
);

// File: tb/uart_fifo_port_bench.sv
`timescale 1ns/100ps
module uart_fifo_port_bench;

    localparam int OSR    = 16;
    localparam int BITCYC = 2 * OSR; // tick every other clock

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_ninth_en = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
    logic       wr_data_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_data_en = 1'b0;
    logic [7:0] rd_data;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       rx_line = 1'b1;
    logic       tx_line, tx_irq, rx_irq;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_fifo_port u_uart_fifo_port (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .cfg_ninth_en(cfg_ninth_en), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd),
        .wr_data_en(wr_data_en), .wr_data(wr_data),
        .rd_data_en(rd_data_en), .rd_data(rd_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rx_line(rx_line), .tx_line(tx_line), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    always @(negedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- transmit reference model (R2, R3, R4, R12) ----------------
    bit m_thr_full, m_busy, m_ti, m_txx;
    bit [7:0] m_thr;
    int m_tcnt;
    bit exp_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_thr_full = 0; m_busy = 0; m_ti = 0; m_txx = 0; m_tcnt = 0;
            exp_q.delete();
        end else begin
            bit was_full, ti_set;
            was_full = m_thr_full;
            ti_set   = 0;
            if (!m_busy && was_full) begin
                exp_q.delete();
                exp_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) exp_q.push_back(m_thr[i]);
                if (cfg_parity_en)
                    exp_q.push_back(cfg_parity_odd ? ~(^m_thr) : (^m_thr));
                else if (cfg_ninth_en)
                    exp_q.push_back(m_txx);
                exp_q.push_back(1'b1);
                m_busy = 1; m_tcnt = 0; m_thr_full = 0;
            end else if (m_busy && baud_tick) begin
                m_tcnt++;
                if (m_tcnt == OSR) begin
                    m_tcnt = 0;
                    void'(exp_q.pop_front());
                    if (exp_q.size() == 1) ti_set = 1;
                    if (exp_q.size() == 0) m_busy = 0;
                end
            end
            if (wr_data_en && !was_full) begin
                m_thr_full = 1; m_thr = wr_data;
            end
            if (ti_set) m_ti = 1;
            else if (ctl_wr_en && !ctl_wdata[1]) m_ti = 0;
            if (ctl_wr_en) m_txx = ctl_wdata[3];
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 tx line", {31'd0, tx_line}, {31'd0, (m_busy ? exp_q[0] : 1'b1)});
            chk("R3 holding empty", {31'd0, ctl_rdata[5]}, {31'd0, ~m_thr_full});
            chk("R4 tx done flag", {31'd0, ctl_rdata[1]}, {31'd0, m_ti});
            chk("R12 tx_irq", {31'd0, tx_irq}, {31'd0, m_ti});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr_en = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr_en = 0;
    endtask

    task automatic data_write(input logic [7:0] v);
        @(negedge clk); wr_data_en = 1; wr_data = v;
        @(negedge clk); wr_data_en = 0;
    endtask

    task automatic pop_byte(output logic [7:0] v);
        @(negedge clk); v = rd_data; rd_data_en = 1;
        @(negedge clk); rd_data_en = 0;
        wait_cyc(2);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit has9, input bit b9, input bit stopv);
        @(negedge clk); rx_line = 0;
        wait_cyc(BITCYC);
        for (int i = 0; i < 8; i++) begin rx_line = d[i]; wait_cyc(BITCYC); end
        if (has9) begin rx_line = b9; wait_cyc(BITCYC); end
        rx_line = stopv; wait_cyc(BITCYC);
        rx_line = 1; wait_cyc(BITCYC);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] v;
        wait_cyc(6);
        rst = 0;
        wait_cyc(2);
        chk("R1 reset status", {24'd0, ctl_rdata}, 32'h20);
        chk("R1 reset tx line", {31'd0, tx_line}, 32'd1);
        chk("R1 reset irqs", {30'd0, tx_irq, rx_irq}, 32'd0);

        // receiver disabled: nothing accepted
        send_frame(8'h55, 0, 0, 1);
        chk("R6 disabled no receive", {31'd0, rx_irq}, 32'd0);

        ctl_write(8'h10);
        send_frame(8'h3C, 0, 0, 1);
        chk("R10 rx done set", {31'd0, ctl_rdata[0]}, 32'd1);
        chk("R12 rx_irq", {31'd0, rx_irq}, 32'd1);
        chk("R5 head byte", {24'd0, rd_data}, 32'h3C);
        chk("R9 stop level high", {31'd0, ctl_rdata[2]}, 32'd1);
        ctl_write(8'h10);
        wait_cyc(2);
        chk("R10 clear refused while queued", {31'd0, ctl_rdata[0]}, 32'd1);
        pop_byte(v);
        chk("R5 popped byte", {24'd0, v}, 32'h3C);
        ctl_write(8'h10);
        wait_cyc(1);
        chk("R10 clear when empty", {31'd0, rx_irq}, 32'd0);

        send_frame(8'h81, 0, 0, 0);
        chk("R9 stop level low", {31'd0, ctl_rdata[2]}, 32'd0);
        pop_byte(v);
        chk("R5 byte 0x81", {24'd0, v}, 32'h81);
        ctl_write(8'h10);

        // readable while disabled
        send_frame(8'h11, 0, 0, 1);
        ctl_write(8'h00);
        send_frame(8'h22, 0, 0, 1);
        pop_byte(v);
        chk("R6 queued byte readable", {24'd0, v}, 32'h11);
        ctl_write(8'h00);
        wait_cyc(1);
        chk("R6 no byte taken while disabled", {31'd0, rx_irq}, 32'd0);
        ctl_write(8'h10);

        // overrun
        for (int i = 0; i < 5; i++) send_frame(8'hA0 + 8'(i), 0, 0, 1);
        chk("R7 overrun set", {31'd0, ctl_rdata[7]}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            pop_byte(v);
            chk("R7 kept order", {24'd0, v}, 32'hA0 + i);
        end
        ctl_write(8'h10);
        wait_cyc(1);
        chk("R7 fifth discarded", {31'd0, rx_irq}, 32'd0);
        chk("R7 overrun cleared by 0", {31'd0, ctl_rdata[7]}, 32'd0);

        // start glitch
        @(negedge clk); rx_line = 0;
        wait_cyc(6);
        rx_line = 1;
        wait_cyc(BITCYC * 12);
        chk("R5 glitch rejected", {31'd0, rx_irq}, 32'd0);

        // parity
        cfg_parity_en = 1; cfg_parity_odd = 0;
        send_frame(8'h07, 1, 0, 1);
        chk("R8 parity error set", {31'd0, ctl_rdata[6]}, 32'd1);
        ctl_write(8'h10);
        wait_cyc(3);
        chk("R8 held while bad head", {31'd0, ctl_rdata[6]}, 32'd1);
        pop_byte(v);
        ctl_write(8'h10);
        wait_cyc(1);
        chk("R8 cleared after pop", {31'd0, ctl_rdata[6]}, 32'd0);
        send_frame(8'h07, 1, 1, 1);
        chk("R8 even parity ok", {31'd0, ctl_rdata[6]}, 32'd0);
        pop_byte(v);
        ctl_write(8'h10);
        cfg_parity_odd = 1;
        send_frame(8'h07, 1, 0, 1);
        chk("R8 odd parity ok", {31'd0, ctl_rdata[6]}, 32'd0);
        pop_byte(v);
        ctl_write(8'h10);

        // extra-bit receive
        cfg_parity_en = 0; cfg_parity_odd = 0; cfg_ninth_en = 1;
        send_frame(8'h5A, 1, 1, 1);
        chk("R9 ninth bit one", {31'd0, ctl_rdata[2]}, 32'd1);
        pop_byte(v);
        chk("R5 ninth-mode byte", {24'd0, v}, 32'h5A);
        send_frame(8'h5A, 1, 0, 1);
        chk("R9 ninth bit zero", {31'd0, ctl_rdata[2]}, 32'd0);
        pop_byte(v);
        ctl_write(8'h10);
        cfg_ninth_en = 0;

        // write semantics
        ctl_write(8'hFF);
        wait_cyc(1);
        chk("R11 write ones", {24'd0, ctl_rdata}, 32'h38);
        ctl_write(8'h10);
        wait_cyc(1);
        chk("R11 plain bits follow write", {24'd0, ctl_rdata}, 32'h30);

        // transmit
        data_write(8'hA5);
        wait_cyc(BITCYC * 11 + 20);
        chk("R4 tx done after frame", {31'd0, tx_irq}, 32'd1);
        ctl_write(8'h10);
        wait_cyc(1);
        chk("R4 tx done cleared", {31'd0, tx_irq}, 32'd0);

        data_write(8'h3C);
        wait_cyc(4);
        data_write(8'hC3);
        chk("R3 holding occupied", {31'd0, ctl_rdata[5]}, 32'd0);
        data_write(8'h99);
        wait_cyc(BITCYC * 24);
        chk("R3 holding empty at end", {31'd0, ctl_rdata[5]}, 32'd1);
        ctl_write(8'h10);

        cfg_ninth_en = 1;
        ctl_write(8'h18);
        data_write(8'h00);
        wait_cyc(BITCYC * 12);
        ctl_write(8'h10);
        cfg_ninth_en = 0; cfg_parity_en = 1;
        data_write(8'h03);
        wait_cyc(BITCYC * 12);
        cfg_parity_odd = 1;
        data_write(8'h03);
        wait_cyc(BITCYC * 12);
        chk("R2 line idle high", {31'd0, tx_line}, 32'd1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule